// File: doc/BRIEF.md
# Push-Button Wake and Reset Controller

This block times how long an active-low push-button is held and turns the press length into system events. A two-flop synchronizer cleans the raw button level. A single elapsed-tick counter then serves a chain of thresholds: a first wake point, a second wake point that follows it, a warning point some ticks before the hardware-reset point, and the hardware-reset point itself. All durations are counts of a prescaled timebase tick that comes from outside the block.

Three events (first wake, second wake, warning) each set a sticky flag and raise an active-low interrupt pulse. The pulse fires only when the flag goes from clear to set, so the host must read the flags, which clears them, before the same event can interrupt again. Reaching the reset point sets a fourth flag and runs the selected long-press action: a power cycle that drops the rail-enable request for a fixed number of ticks, a request to enter ship mode once the button is let go, or nothing. In ship mode a press only counts towards the first wake point, and reaching it requests a ship-mode exit. A valid input supply also forces that exit.

Top module: `pbwr_ctrl`

## Requirements
- R1: The button counts as pressed two clock edges after `btn_n` goes low. Holding it for `dur_w1` ticks sets `flags[0]` and drives `int_n` low for `PULSE_CYC` clock cycles. A release before that point sets no flag.
- R2: If the press lasts `dur_w1 + dur_w2` ticks, `flags[1]` is set and another interrupt pulse is sent. The second wake point has no other effect.
- R3: A flag stays set until a `flag_rd` strobe, which clears all four flags. An event that sets a flag wins over a read in the same cycle. An interrupt pulse starts only when an interrupting flag goes from 0 to 1, so a repeated event with its flag still set gives no pulse.
- R4: At `dur_hr - dur_warn` ticks (or the first tick if `dur_warn >= dur_hr`), `flags[2]` is set and an interrupt pulse is sent.
- R5: At `dur_hr` ticks, `flags[3]` is set with no interrupt, and the action coded on `lp_act` runs: 2'b00 power cycle, 2'b01 enter ship mode, 2'b10 or 2'b11 no action, so `rail_en` stays high.
- R6: A power cycle drives `rail_en` low for `RESTART_TICKS` ticks, then high again. `rail_en` is also low whenever `ship_st` is high.
- R7: With the ship action, `ship_req` pulses for one cycle only after the button is released, never while it is held.
- R8: While `ship_st` is high, no flag or interrupt is produced. A press that reaches `dur_w1` raises `ship_exit`. A press released earlier leaves the block in ship mode with `rail_en` low.
- R9: While `ship_st` is high, `vin_ok` high raises `ship_exit` at once, unless the current press has already passed the second wake point.
- R10: After a ship-mode exit with the button still held, no flag, interrupt or long-press action happens until the button is released and pressed again.
- R11: Durations are captured when a press starts. A change made during a press applies from the next press.
- R12: During a press, `lp_act` may move away from the power-cycle code and the new action applies. A move to the power-cycle code from any other action is ignored until release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase tick that all durations count |
| btn_n | input | 1 | Raw active-low button level |
| vin_ok | input | 1 | Valid input supply present |
| ship_st | input | 1 | System is currently in ship mode |
| dur_w1 | input | CNT_W | First wake duration in ticks |
| dur_w2 | input | CNT_W | Extra ticks from first to second wake point |
| dur_warn | input | CNT_W | Warning lead before the reset point, in ticks |
| dur_hr | input | CNT_W | Hardware-reset duration in ticks |
| lp_act | input | 2 | Long-press action select |
| flag_rd | input | 1 | Read strobe that clears all flags |
| flags | output | 4 | {reset, warning, wake2, wake1} sticky flags |
| int_n | output | 1 | Active-low interrupt pulse |
| rail_en | output | 1 | Request to power the system rails |
| ship_exit | output | 1 | Request to leave ship mode |
| ship_req | output | 1 | One-cycle request to enter ship mode |

## Verification
The assertions check on every cycle that flags drop only after a read strobe and that each interrupt falling edge matches a freshly set interrupting flag. They also check that a ship-mode request never follows a held button, that an exit request only comes out of ship mode, that a locked press sets nothing, and that a rail drop always has a reset expiry or ship entry behind it. Tick-exact threshold placement, pulse and restart lengths, refusal of a late switch to power cycle, the cancelled early wake and the latched durations can only be shown by the bench's scenarios against its cycle model.

// File: rtl/pbwr_pkg.sv
package pbwr_pkg;

    typedef enum logic [1:0] {
        ACT_CYCLE = 2'b00,
        ACT_SHIP  = 2'b01,
        ACT_NONE  = 2'b10,
        ACT_HOLD  = 2'b11
    } lp_act_e;

    localparam int NEV     = 4;
    localparam int EV_W1   = 0;
    localparam int EV_W2   = 1;
    localparam int EV_WARN = 2;
    localparam int EV_HR   = 3;

    // events that raise an interrupt pulse when their flag becomes set
    localparam logic [NEV-1:0] IRQ_MASK = 4'b0111;

    // bit order equals the flag index order above
    typedef struct packed {
        logic hr;
        logic warn;
        logic w2;
        logic w1;
    } press_ev_t;

    // warning point: lead ticks before the reset point, clamped at zero
    function automatic int unsigned warn_point(input int unsigned hr_ticks,
                                               input int unsigned lead_ticks);
        return (hr_ticks > lead_ticks) ? hr_ticks - lead_ticks : 0;
    endfunction

endpackage

// File: rtl/pbwr_sync.sv
module pbwr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbwr_press_timer.sv
module pbwr_press_timer
    import pbwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pressed,
    input  logic [CNT_W-1:0] dur_w1,
    input  logic [CNT_W-1:0] dur_w2,
    input  logic [CNT_W-1:0] dur_lead,
    input  logic [CNT_W-1:0] dur_hr,
    output press_ev_t        ev,
    output logic             w2_done
);
    localparam int             EL_W   = CNT_W + 1;
    localparam logic [EL_W-1:0] EL_MAX = '1;

    logic [EL_W-1:0]  elapsed;
    logic [EL_W-1:0]  el_next;
    logic [CNT_W-1:0] dur_in [NEV];
    logic [CNT_W-1:0] shadow [NEV];
    logic [EL_W-1:0]  thr    [NEV];
    logic [NEV-1:0]   done;
    logic [NEV-1:0]   hit;

    assign dur_in[EV_W1]   = dur_w1;
    assign dur_in[EV_W2]   = dur_w2;
    assign dur_in[EV_WARN] = dur_lead;
    assign dur_in[EV_HR]   = dur_hr;

    assign el_next = elapsed + 1'b1;

    // elapsed ticks of the current press, saturating
    always_ff @(posedge clk) begin
        if (rst || !pressed)                   elapsed <= '0;
        else if (tick && elapsed != EL_MAX)    elapsed <= el_next;
    end

    // durations are frozen for the length of a press
    always_ff @(posedge clk) begin
        for (int i = 0; i < NEV; i++) begin
            if (rst)           shadow[i] <= '0;
            else if (!pressed) shadow[i] <= dur_in[i];
        end
    end

    // chained thresholds: wake2 follows wake1, warning leads reset
    always_comb begin
        thr[EV_W1]   = {1'b0, shadow[EV_W1]};
        thr[EV_W2]   = {1'b0, shadow[EV_W1]} + {1'b0, shadow[EV_W2]};
        thr[EV_WARN] = EL_W'(warn_point(32'(shadow[EV_HR]), 32'(shadow[EV_WARN])));
        thr[EV_HR]   = {1'b0, shadow[EV_HR]};
    end

    generate
        for (genvar g = 0; g < NEV; g++) begin : g_hit
            assign hit[g] = pressed && tick && !done[g] && (el_next >= thr[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < NEV; i++) begin
            if (rst || !pressed) done[i] <= 1'b0;
            else if (hit[i])     done[i] <= 1'b1;
        end
    end

    assign ev      = press_ev_t'(hit);
    assign w2_done = done[EV_W2];
endmodule

// File: rtl/pbwr_flag_irq.sv
module pbwr_flag_irq #(
    parameter int            NF        = 4,
    parameter int            PULSE_CYC = 8,
    parameter logic [NF-1:0] IRQ_EN    = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_ev,
    input  logic          rd_clr,
    output logic [NF-1:0] flags,
    output logic          int_n
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [NF-1:0] fresh;
    logic [PW-1:0] pcnt;

    generate
        for (genvar g = 0; g < NF; g++) begin : g_fresh
            assign fresh[g] = set_ev[g] && !flags[g] && IRQ_EN[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < NF; i++) begin
            if (rst)            flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (rd_clr)    flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              pcnt <= '0;
        else if (|fresh)      pcnt <= PW'(PULSE_CYC);
        else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
    end

    assign int_n = (pcnt == '0);
endmodule

// File: rtl/pbwr_action.sv
module pbwr_action
    import pbwr_pkg::*;
#(
    parameter int RESTART_TICKS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    pressed,
    input  logic    ship_st,
    input  logic    vin_ok,
    input  logic    w1_hit,
    input  logic    hr_hit,
    input  logic    w2_done,
    input  lp_act_e act_sel,
    output logic    gate,
    output logic    lock_q,
    output logic    ship_exit,
    output logic    ship_req,
    output logic    rail_en
);
    localparam int PW = $clog2(RESTART_TICKS + 1);

    lp_act_e       eff_act;
    logic          pend;
    logic [PW-1:0] pc_left;
    logic          exit_c;
    logic          fire;

    assign gate   = !lock_q && !ship_st;
    assign exit_c = ship_st && ((w1_hit && !lock_q) || (vin_ok && !w2_done));
    assign fire   = hr_hit && gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            eff_act   <= ACT_NONE;
            pend      <= 1'b0;
            pc_left   <= '0;
            ship_exit <= 1'b0;
            ship_req  <= 1'b0;
        end else begin
            lock_q    <= pressed && (lock_q || exit_c);
            ship_exit <= exit_c;
            ship_req  <= pend && !pressed;

            if (pend && !pressed)                  pend <= 1'b0;
            else if (fire && eff_act == ACT_SHIP)  pend <= 1'b1;

            if (fire && eff_act == ACT_CYCLE)      pc_left <= PW'(RESTART_TICKS);
            else if (tick && pc_left != '0)        pc_left <= pc_left - 1'b1;

            // a move onto the power-cycle code is refused mid-press
            if (!pressed || act_sel != ACT_CYCLE)  eff_act <= act_sel;
        end
    end

    assign rail_en = !ship_st && (pc_left == '0);
endmodule

// File: rtl/pbwr_ctrl.sv
module pbwr_ctrl
    import pbwr_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int PULSE_CYC     = 6400,
    parameter int RESTART_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             btn_n,
    input  logic             vin_ok,
    input  logic             ship_st,
    input  logic [CNT_W-1:0] dur_w1,
    input  logic [CNT_W-1:0] dur_w2,
    input  logic [CNT_W-1:0] dur_warn,
    input  logic [CNT_W-1:0] dur_hr,
    input  logic [1:0]       lp_act,
    input  logic             flag_rd,
    output logic [3:0]       flags,
    output logic             int_n,
    output logic             rail_en,
    output logic             ship_exit,
    output logic             ship_req
);
    logic           btn_low;
    press_ev_t      ev_raw;
    logic [NEV-1:0] ev_set;
    logic           w2_done;
    logic           gate;
    logic           lock_q;
    logic           hr_ev;

    pbwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (~btn_n),
        .q   (btn_low)
    );

    pbwr_press_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pressed  (btn_low),
        .dur_w1   (dur_w1),
        .dur_w2   (dur_w2),
        .dur_lead (dur_warn),
        .dur_hr   (dur_hr),
        .ev       (ev_raw),
        .w2_done  (w2_done)
    );

    assign hr_ev = ev_raw.hr;

    pbwr_action #(.RESTART_TICKS(RESTART_TICKS)) u_action (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .pressed   (btn_low),
        .ship_st   (ship_st),
        .vin_ok    (vin_ok),
        .w1_hit    (ev_raw.w1),
        .hr_hit    (hr_ev),
        .w2_done   (w2_done),
        .act_sel   (lp_act_e'(lp_act)),
        .gate      (gate),
        .lock_q    (lock_q),
        .ship_exit (ship_exit),
        .ship_req  (ship_req),
        .rail_en   (rail_en)
    );

    assign ev_set = ev_raw & {NEV{gate}};

    pbwr_flag_irq #(.NF(NEV), .PULSE_CYC(PULSE_CYC), .IRQ_EN(IRQ_MASK)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_ev (ev_set),
        .rd_clr (flag_rd),
        .flags  (flags),
        .int_n  (int_n)
    );
endmodule

// File: rtl/pbwr_ctrl_chk.sv
module pbwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] flags,
    input logic       int_n,
    input logic       rail_en,
    input logic       ship_st,
    input logic       ship_exit,
    input logic       ship_req,
    input logic       flag_rd,
    input logic       btn_low,
    input logic       lock_q,
    input logic       hr_ev
);
    a_r3_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
        (|($past(flags) & ~flags)) |-> $past(flag_rd));

    a_r3_int_on_new_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> (|(flags & ~$past(flags) & 4'b0111)));

    a_r7_ship_req_after_release: assert property (@(posedge clk) disable iff (rst)
        ship_req |-> !$past(btn_low));

    a_r8_exit_from_ship_only: assert property (@(posedge clk) disable iff (rst)
        ship_exit |-> $past(ship_st));

    a_r10_locked_press_mute: assert property (@(posedge clk) disable iff (rst)
        $past(lock_q) |-> ((flags & ~$past(flags)) == 4'b0000));

    a_r6_rail_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(rail_en) |-> ($past(hr_ev) || $rose(ship_st)));
endmodule

bind pbwr_ctrl pbwr_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .int_n     (int_n),
    .rail_en   (rail_en),
    .ship_st   (ship_st),
    .ship_exit (ship_exit),
    .ship_req  (ship_req),
    .flag_rd   (flag_rd),
    .btn_low   (btn_low),
    .lock_q    (lock_q),
    .hr_ev     (hr_ev)
);

// File: tb/tb_pbwr_ctrl.sv
module tb_pbwr_ctrl;
    localparam int CW    = 8;
    localparam int PULSE = 6;
    localparam int RST_T = 5;
    localparam int TDIV  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          btn_n = 1'b1;
    logic          vin_ok = 1'b0;
    logic          ship_st = 1'b0;
    logic          flag_rd = 1'b0;
    logic [CW-1:0] d_w1 = 8'd5;
    logic [CW-1:0] d_w2 = 8'd4;
    logic [CW-1:0] d_warn = 8'd3;
    logic [CW-1:0] d_hr = 8'd20;
    logic [1:0]    lp_act = 2'b10;
    logic [3:0]    flags;
    logic          int_n, rail_en, ship_exit, ship_req;

    pbwr_ctrl #(.CNT_W(CW), .SYNC_STAGES(2), .PULSE_CYC(PULSE), .RESTART_TICKS(RST_T)) dut (
        .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n), .vin_ok(vin_ok),
        .ship_st(ship_st), .dur_w1(d_w1), .dur_w2(d_w2), .dur_warn(d_warn),
        .dur_hr(d_hr), .lp_act(lp_act), .flag_rd(flag_rd), .flags(flags),
        .int_n(int_n), .rail_en(rail_en), .ship_exit(ship_exit), .ship_req(ship_req)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int nfall = 0, nrail = 0, nsreq = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // timebase tick and ship-state environment
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick = ((c % TDIV) == TDIV - 1);
            c++;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (ship_exit) ship_st = 1'b0;
            if (ship_req)  ship_st = 1'b1;
        end
    end

    // behavioural reference model
    int m_s1, m_s2, m_el, m_lock, m_eff, m_pend, m_pcl, m_pc, m_exit, m_sreq;
    int m_sh[4];
    int m_d[4];
    int th[4];
    bit hit[4];
    logic [3:0] m_fl;
    bit pr, gate, exitc, nreq;
    int e1;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_el = 0; m_lock = 0; m_eff = 2; m_pend = 0;
            m_pcl = 0; m_pc = 0; m_exit = 0; m_sreq = 0; m_fl = 4'b0;
            for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_d[i] = 0; end
        end else begin
            pr = (m_s2 != 0);
            e1 = m_el + 1;
            th[0] = m_sh[0];
            th[1] = m_sh[0] + m_sh[1];
            th[2] = (m_sh[3] > m_sh[2]) ? m_sh[3] - m_sh[2] : 0;
            th[3] = m_sh[3];
            for (int i = 0; i < 4; i++) hit[i] = pr && tick && (m_d[i] == 0) && (e1 >= th[i]);
            gate  = (m_lock == 0) && !ship_st;
            exitc = ship_st && ((hit[0] && m_lock == 0) || (vin_ok && m_d[1] == 0));
            nreq = 0;
            for (int i = 0; i < 4; i++) begin
                if (hit[i] && gate) begin
                    if (!m_fl[i] && i < 3) nreq = 1;
                    m_fl[i] = 1'b1;
                end else if (flag_rd) m_fl[i] = 1'b0;
            end
            if (nreq) m_pc = PULSE; else if (m_pc > 0) m_pc--;
            m_exit = exitc;
            m_sreq = (m_pend != 0) && !pr;
            if (m_pend != 0 && !pr) m_pend = 0;
            else if (hit[3] && gate && m_eff == 1) m_pend = 1;
            if (hit[3] && gate && m_eff == 0) m_pcl = RST_T;
            else if (tick && m_pcl > 0) m_pcl--;
            if (!pr || lp_act != 2'b00) m_eff = int'(lp_act);
            m_lock = (pr && (m_lock != 0 || exitc)) ? 1 : 0;
            if (!pr) m_el = 0; else if (tick && m_el < 511) m_el++;
            for (int i = 0; i < 4; i++) begin
                if (!pr) m_d[i] = 0; else if (hit[i]) m_d[i] = 1;
            end
            if (!pr) begin
                m_sh[0] = int'(d_w1); m_sh[1] = int'(d_w2);
                m_sh[2] = int'(d_warn); m_sh[3] = int'(d_hr);
            end
            m_s2 = m_s1;
            m_s1 = btn_n ? 0 : 1;
        end
    end

    // per-cycle comparison, away from both clock edges
    initial begin
        bit prev_int = 1'b1;
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                chk(flags == m_fl, "R3 flag vector", int'(flags), int'(m_fl));
                chk(int_n == (m_pc == 0), "R1 int_n", int'(int_n), int'(m_pc == 0));
                chk(rail_en == (!ship_st && m_pcl == 0), "R6 rail_en", int'(rail_en),
                    int'(!ship_st && m_pcl == 0));
                chk(ship_exit == (m_exit != 0), "R8 ship_exit", int'(ship_exit), m_exit);
                chk(ship_req == (m_sreq != 0), "R7 ship_req", int'(ship_req), m_sreq);
                if (prev_int && !int_n) nfall++;
                prev_int = int_n;
                if (!rail_en && !ship_st) nrail++;
                if (ship_req) nsreq++;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic hold(input int n);
        btn_n = 1'b0;
        idle(n);
        btn_n = 1'b1;
        idle(3);
    endtask

    task automatic rd();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f0, r0, s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(flags == 4'b0, "R3 reset flags", int'(flags), 0);
        chk(int_n == 1'b1, "R1 reset int_n", int'(int_n), 1);
        chk(rail_en == 1'b1, "R6 reset rail_en", int'(rail_en), 1);
        chk(!ship_req && !ship_exit, "R8 reset requests", int'(ship_req | ship_exit), 0);

        // short press below first wake
        hold(2);
        chk(flags == 4'b0, "R1 short press no flag", int'(flags), 0);

        // both wake points
        f0 = nfall;
        hold(12);
        chk(flags == 4'b0011, "R2 wake flags", int'(flags), 3);
        chk(nfall - f0 == 2, "R1 two interrupt pulses", nfall - f0, 2);
        idle(4);
        chk(flags == 4'b0011, "R3 flags sticky", int'(flags), 3);
        rd();
        idle(1);
        chk(flags == 4'b0, "R3 read clears", int'(flags), 0);

        // repeat without reading: no new interrupt
        hold(12);
        f0 = nfall;
        hold(12);
        chk(nfall == f0, "R3 no pulse with flags set", nfall - f0, 0);
        rd();

        // long press, no action
        lp_act = 2'b10;
        f0 = nfall; r0 = nrail;
        hold(24);
        chk(flags == 4'b1111, "R5 all flags", int'(flags), 15);
        chk(nfall - f0 == 3, "R4 warning pulse counted", nfall - f0, 3);
        chk(nrail == r0, "R5 no action keeps rail", nrail - r0, 0);
        rd();

        // power cycle
        lp_act = 2'b00;
        r0 = nrail;
        hold(24);
        chk((nrail - r0 >= (RST_T - 1) * TDIV) && (nrail - r0 <= RST_T * TDIV + 1),
            "R6 restart length", nrail - r0, RST_T * TDIV);
        chk(rail_en == 1'b1, "R6 rail restored", int'(rail_en), 1);
        rd();

        // ship action waits for release
        lp_act = 2'b01;
        s0 = nsreq;
        btn_n = 1'b0;
        idle(24);
        chk(nsreq == s0 && !ship_st, "R7 no request while held", nsreq - s0, 0);
        btn_n = 1'b1;
        idle(2);
        chk(nsreq - s0 == 1, "R7 single request", nsreq - s0, 1);
        chk(ship_st == 1'b1, "R7 ship entered", int'(ship_st), 1);
        chk(rail_en == 1'b0, "R8 rails off in ship", int'(rail_en), 0);
        rd();

        // ship wake: early release, then full wake with lockout
        hold(2);
        chk(ship_st == 1'b1, "R8 early release stays", int'(ship_st), 1);
        btn_n = 1'b0;
        idle(7);
        chk(ship_st == 1'b0, "R8 wake exit", int'(ship_st), 0);
        chk(rail_en == 1'b1, "R8 rails on after exit", int'(rail_en), 1);
        idle(23);
        chk(flags == 4'b0, "R10 locked press sets nothing", int'(flags), 0);
        chk(ship_st == 1'b0, "R10 no long action", int'(ship_st), 0);
        btn_n = 1'b1;
        idle(3);
        hold(7);
        chk(flags == 4'b0001, "R10 fresh press counts", int'(flags), 1);
        rd();
        lp_act = 2'b10;

        // supply forces exit
        @(negedge clk); ship_st = 1'b1;
        vin_ok = 1'b1;
        idle(1);
        chk(ship_st == 1'b0, "R9 supply exit", int'(ship_st), 0);
        vin_ok = 1'b0;
        idle(1);

        // reprogramming during a press is deferred
        btn_n = 1'b0;
        idle(2);
        d_w1 = 8'd30;
        idle(5);
        chk(flags[0] == 1'b1, "R11 captured duration kept", int'(flags[0]), 1);
        btn_n = 1'b1;
        idle(3);
        rd();
        d_w1 = 8'd8;
        hold(6);
        chk(flags[0] == 1'b0, "R11 new duration on next press", int'(flags[0]), 0);
        d_w1 = 8'd5;
        rd();

        // action change rules
        r0 = nrail;
        btn_n = 1'b0;
        idle(3);
        lp_act = 2'b00;
        idle(21);
        btn_n = 1'b1;
        idle(3);
        chk(nrail == r0, "R12 switch to cycle refused", nrail - r0, 0);
        r0 = nrail;
        btn_n = 1'b0;
        idle(3);
        lp_act = 2'b10;
        idle(21);
        btn_n = 1'b1;
        idle(3);
        chk(nrail == r0, "R12 switch away from cycle", nrail - r0, 0);
        rd();
        idle(2);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule